// File: doc/BRIEF.md
# SD Host Normal Interrupt Status Logic

This block holds the normal interrupt status bits of an SD/MMC host controller. It watches four live present-state levels: card presence, buffer-readable, buffer-writable and the card's own interrupt line. Edges on the first three are caught and held in sticky status bits until software clears them. The card interrupt line is tracked as a level, not held. In 4-bit bus mode the line is only valid during the interrupt cycle, so it is sampled only while a qualifier input marks that window.

Software reaches the block through a small register port with a synchronous write and a combinational read. There is a status register whose sticky bits clear when a 1 is written to them. There is a status-enable register that decides which bits may record events at all. There is a signal-enable register that decides which recorded bits raise the single host interrupt output. The card interrupt bit cannot be cleared by a write. Software silences it by dropping its status-enable bit, services the card, and then sets the enable again.

Top module: `sdirq_top`

## Requirements
- R1: Status bit 7 (card gone) sets on the cycle after the card-present input falls from 1 to 0, provided its status-enable bit is 1.
- R2: Status bit 6 (card arrived) sets on the cycle after the card-present input rises from 0 to 1, provided its status-enable bit is 1.
- R3: Status bit 5 (read buffer ready) sets on the cycle after the buffer-readable input rises. A falling edge of that input sets nothing and clears nothing.
- R4: Status bit 4 (write buffer ready) sets on the cycle after the buffer-writable input rises.
- R5: A write to address 0 clears each of bits 7..4 that has a 1 in the write data. Bits written as 0 keep their value.
- R6: When a set event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: After reset the status, status-enable and signal-enable registers all read 0, and the interrupt output is low. No edge is reported for input levels already present when reset is released.
- R8: A status bit whose status-enable bit is 0 never sets and reads as 0. Clearing the enable of a set bit makes that bit read 0 from the second cycle after the write.
- R9: Status bit 8 (card interrupt) follows the card interrupt line with one cycle of delay. In 1-bit mode the line is sampled every cycle. In 4-bit mode it is sampled only while the window input is 1, and otherwise the bit holds its last value.
- R10: Bit 8 ignores writes to address 0. It reads 0 from the second cycle after its status-enable bit is written to 0, and it stays 0 until the enable is set again.
- R11: The interrupt output is high exactly one cycle after any status bit and its matching signal-enable bit are both 1.
- R12: Address 0 is status, 1 is status enable, 2 is signal enable, and 3 reads 0. Only bits 8..4 are implemented, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| card_present | input | 1 | Live card-inserted level |
| rd_buf_avail | input | 1 | Live buffer-readable level |
| wr_buf_avail | input | 1 | Live buffer-writable level |
| card_irq_line | input | 1 | Card interrupt line, active high |
| irq_window | input | 1 | Marks the interrupt cycle in 4-bit mode |
| bus_4bit | input | 1 | 1 when the bus runs in 4-bit mode |
| reg_wr | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Write address |
| reg_wr_data | input | 16 | Write data |
| reg_rd_addr | input | 2 | Read address |
| reg_rd_data | output | 16 | Read data, combinational |
| host_irq | output | 1 | Registered interrupt to the host system |

## Verification
The bench drives a buffer-readable rising edge in the same cycle as a clearing write to that bit. A design that let the clear win would lose the event and read bit 5 as 0. It checks that a falling edge of buffer-readable does nothing, and that card presence is reported on both edges. A design that detected only one polarity would miss either bit 6 or bit 7. In 4-bit mode the card line is changed outside and inside the window, so a sampler that ignored the window would follow the line early. It also writes 1 to bit 8 and drops its enable, so a design that cleared bit 8 by a write, or kept it after the enable dropped, would show the wrong value. The interrupt output is sampled both in the cycle a status bit appears and one cycle later, and again while the signal enables change, which exposes any output that has the wrong latency.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;

    localparam int REG_W     = 16;
    localparam int ADDR_W    = 2;
    localparam int NUM_EDGE  = 4;
    localparam int EDGE_LSB  = 4;
    localparam int BIT_CARD  = 8;

    // Implemented bits of every register: 8..4
    localparam logic [REG_W-1:0] IMPL_MASK = 16'h01F0;

    // Polarity per edge bit, index 0 = bit 4 ... index 3 = bit 7; 1 = rising
    localparam logic [NUM_EDGE-1:0] RISE_SEL = 4'b0111;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_ST_EN  = 2'd1,
        SEL_SIG_EN = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic gone;     // bit 7
        logic arrived;  // bit 6
        logic rd_rdy;   // bit 5
        logic wr_rdy;   // bit 4
    } edge_evt_t;

    function automatic logic [REG_W-1:0] compose_status(
        input logic [NUM_EDGE-1:0] sticky,
        input logic                card
    );
        logic [REG_W-1:0] w;
        w = '0;
        w[EDGE_LSB +: NUM_EDGE] = sticky;
        w[BIT_CARD]             = card;
        return w;
    endfunction

endpackage

// File: rtl/sdirq_edge.sv
module sdirq_edge #(
    parameter int              N        = 4,
    parameter logic [N-1:0]    RISE_SEL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] evt
);
    logic [N-1:0] prev_q;

    // During reset the history tracks the live level, so no edge at release
    always_ff @(posedge clk) begin
        prev_q <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_pol
        if (RISE_SEL[i]) begin : g_rise
            assign evt[i] = !rst && lvl[i] && !prev_q[i];
        end else begin : g_fall
            assign evt[i] = !rst && !lvl[i] && prev_q[i];
        end
    end
endmodule

// File: rtl/sdirq_latch.sv
module sdirq_latch #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] stat
);
    logic [N-1:0] stat_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                stat_q[i] <= 1'b0;
            else if (!en[i])
                stat_q[i] <= 1'b0;
            else if (evt[i])
                stat_q[i] <= 1'b1;       // set beats clear
            else if (clr[i])
                stat_q[i] <= 1'b0;
        end
    end

    assign stat = stat_q;
endmodule

// File: rtl/sdirq_card.sv
module sdirq_card (
    input  logic clk,
    input  logic rst,
    input  logic line,
    input  logic window,
    input  logic bus_4bit,
    input  logic en,
    output logic stat
);
    logic smp_q;
    logic take;

    assign take = !bus_4bit || window;

    always_ff @(posedge clk) begin
        if (rst || !en)
            smp_q <= 1'b0;
        else if (take)
            smp_q <= line;
    end

    assign stat = smp_q;
endmodule

// File: rtl/sdirq_top.sv
module sdirq_top
    import sdirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              card_present,
    input  logic              rd_buf_avail,
    input  logic              wr_buf_avail,
    input  logic              card_irq_line,
    input  logic              irq_window,
    input  logic              bus_4bit,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [REG_W-1:0]  reg_wr_data,
    input  logic [ADDR_W-1:0] reg_rd_addr,
    output logic [REG_W-1:0]  reg_rd_data,
    output logic              host_irq
);
    logic [REG_W-1:0]    st_en_q;
    logic [REG_W-1:0]    sig_en_q;
    logic                irq_q;
    edge_evt_t           evt;
    edge_evt_t           lvl;
    logic [NUM_EDGE-1:0] clr;
    logic [NUM_EDGE-1:0] sticky;
    logic                card_stat;
    logic [REG_W-1:0]    status;
    reg_sel_e            wsel;
    reg_sel_e            rsel;

    assign wsel = reg_sel_e'(reg_wr_addr);
    assign rsel = reg_sel_e'(reg_rd_addr);

    assign lvl = '{gone: card_present, arrived: card_present,
                   rd_rdy: rd_buf_avail, wr_rdy: wr_buf_avail};

    sdirq_edge #(.N(NUM_EDGE), .RISE_SEL(RISE_SEL)) u_edge (
        .clk (clk),
        .rst (rst),
        .lvl (lvl),
        .evt (evt)
    );

    assign clr = (reg_wr && wsel == SEL_STATUS) ?
                 reg_wr_data[EDGE_LSB +: NUM_EDGE] : '0;

    sdirq_latch #(.N(NUM_EDGE)) u_latch (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .clr  (clr),
        .en   (st_en_q[EDGE_LSB +: NUM_EDGE]),
        .stat (sticky)
    );

    sdirq_card u_card (
        .clk      (clk),
        .rst      (rst),
        .line     (card_irq_line),
        .window   (irq_window),
        .bus_4bit (bus_4bit),
        .en       (st_en_q[BIT_CARD]),
        .stat     (card_stat)
    );

    assign status = compose_status(sticky, card_stat);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_en_q  <= '0;
            sig_en_q <= '0;
        end else if (reg_wr) begin
            if (wsel == SEL_ST_EN)  st_en_q  <= reg_wr_data & IMPL_MASK;
            if (wsel == SEL_SIG_EN) sig_en_q <= reg_wr_data & IMPL_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(status & sig_en_q);
    end
    assign host_irq = irq_q;

    always_comb begin
        unique case (rsel)
            SEL_STATUS: reg_rd_data = status;
            SEL_ST_EN:  reg_rd_data = st_en_q;
            SEL_SIG_EN: reg_rd_data = sig_en_q;
            default:    reg_rd_data = '0;
        endcase
    end

    // ---------------- assertions ----------------
    assert_gone_R1: assert property (@(posedge clk) disable iff (rst)
        (evt.gone && st_en_q[7]) |=> status[7]);
    assert_arrived_R2: assert property (@(posedge clk) disable iff (rst)
        (evt.arrived && st_en_q[6]) |=> status[6]);
    assert_rdrdy_R3: assert property (@(posedge clk) disable iff (rst)
        (evt.rd_rdy && st_en_q[5]) |=> status[5]);
    assert_wrrdy_R4: assert property (@(posedge clk) disable iff (rst)
        (evt.wr_rdy && st_en_q[4]) |=> status[4]);
    assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && wsel == SEL_STATUS && reg_wr_data[7] && !evt.gone) |=> !status[7]);
    assert_setwins_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && wsel == SEL_STATUS && reg_wr_data[5] && evt.rd_rdy && st_en_q[5])
        |=> status[5]);
    assert_masked_R8: assert property (@(posedge clk) disable iff (rst)
        !st_en_q[4] |=> !status[4]);
    assert_card_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_4bit && !irq_window && st_en_q[BIT_CARD]) |=> $stable(status[BIT_CARD]));
    assert_card_off_R10: assert property (@(posedge clk) disable iff (rst)
        !st_en_q[BIT_CARD] |=> !status[BIT_CARD]);
    assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        ((status & sig_en_q) == '0) |=> !host_irq);

    always_comb begin
        assert_rsvd_R12: assert ((reg_rd_data & ~IMPL_MASK) == '0);
    end
endmodule

// File: tb/sdirq_top_bench.sv
module sdirq_top_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        card_present, rd_buf_avail, wr_buf_avail;
    logic        card_irq_line, irq_window, bus_4bit;
    logic        reg_wr;
    logic [1:0]  reg_wr_addr, reg_rd_addr;
    logic [15:0] reg_wr_data, reg_rd_data;
    logic        host_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    sdirq_top u_sdirq_top (
        .clk(clk), .rst(rst),
        .card_present(card_present), .rd_buf_avail(rd_buf_avail),
        .wr_buf_avail(wr_buf_avail), .card_irq_line(card_irq_line),
        .irq_window(irq_window), .bus_4bit(bus_4bit),
        .reg_wr(reg_wr), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .host_irq(host_irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [15:0] exp);
        reg_rd_addr = a;
        #1;
        check(req, reg_rd_data, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        tick();
        reg_wr = 1'b0; reg_wr_data = '0;
    endtask

    task automatic t_reset();
        rd_chk("R7", 2'd0, 16'h0000);
        rd_chk("R7", 2'd1, 16'h0000);
        rd_chk("R7", 2'd2, 16'h0000);
        check("R7", {15'd0, host_irq}, 16'd0);
        wr(2'd1, 16'h01F0);
        wr(2'd2, 16'h01F0);
        tick();
        rd_chk("R7 no edge at release", 2'd0, 16'h0000);
    endtask

    task automatic t_card_edges();
        card_present = 1'b1;
        tick();
        rd_chk("R2", 2'd0, 16'h0040);
        check("R11 latency", {15'd0, host_irq}, 16'd0);
        tick();
        check("R11", {15'd0, host_irq}, 16'd1);
        wr(2'd0, 16'h0040);
        rd_chk("R5", 2'd0, 16'h0000);
        card_present = 1'b0;
        tick();
        rd_chk("R1", 2'd0, 16'h0080);
        wr(2'd0, 16'h0000);
        rd_chk("R5 zero keeps", 2'd0, 16'h0080);
        wr(2'd0, 16'h0080);
        rd_chk("R5", 2'd0, 16'h0000);
    endtask

    task automatic t_buffers();
        rd_buf_avail = 1'b1;
        tick();
        rd_chk("R3", 2'd0, 16'h0020);
        rd_buf_avail = 1'b0;
        tick();
        rd_chk("R3 fall no effect", 2'd0, 16'h0020);
        wr(2'd0, 16'h0020);
        wr_buf_avail = 1'b1;
        tick();
        rd_chk("R4", 2'd0, 16'h0010);
        wr(2'd0, 16'h0010);
        rd_chk("R4 cleared", 2'd0, 16'h0000);
    endtask

    task automatic t_collision();
        rd_buf_avail = 1'b1;
        wr(2'd0, 16'h0020);
        rd_chk("R6", 2'd0, 16'h0020);
        wr(2'd0, 16'h0020);
        rd_chk("R6 later clear", 2'd0, 16'h0000);
        rd_buf_avail = 1'b0;
        tick();
    endtask

    task automatic t_mask();
        wr(2'd1, 16'h0100);
        wr_buf_avail = 1'b0;
        tick();
        wr_buf_avail = 1'b1;
        tick();
        rd_chk("R8 masked", 2'd0, 16'h0000);
        wr(2'd1, 16'h01F0);
        tick();
        rd_chk("R8 no late set", 2'd0, 16'h0000);
        card_present = 1'b1;
        tick();
        rd_chk("R8 setup", 2'd0, 16'h0040);
        wr(2'd1, 16'h01B0);
        tick();
        rd_chk("R8 drop clears", 2'd0, 16'h0000);
        wr(2'd1, 16'h01F0);
    endtask

    task automatic t_card_irq();
        bus_4bit = 1'b0; card_irq_line = 1'b1;
        tick();
        rd_chk("R9 1-bit", 2'd0, 16'h0100);
        wr(2'd0, 16'h0100);
        rd_chk("R10 w1c ignored", 2'd0, 16'h0100);
        card_irq_line = 1'b0;
        tick();
        rd_chk("R9 follows", 2'd0, 16'h0000);
        bus_4bit = 1'b1; irq_window = 1'b0; card_irq_line = 1'b1;
        tick();
        rd_chk("R9 outside window", 2'd0, 16'h0000);
        irq_window = 1'b1;
        tick();
        rd_chk("R9 in window", 2'd0, 16'h0100);
        irq_window = 1'b0; card_irq_line = 1'b0;
        tick();
        rd_chk("R9 hold", 2'd0, 16'h0100);
        wr(2'd1, 16'h00F0);
        tick();
        rd_chk("R10 enable drop", 2'd0, 16'h0000);
        card_irq_line = 1'b1; irq_window = 1'b1;
        tick();
        rd_chk("R10 stays off", 2'd0, 16'h0000);
        wr(2'd1, 16'h01F0);
        tick();
        rd_chk("R10 resample", 2'd0, 16'h0100);
        card_irq_line = 1'b0;
        tick();
        rd_chk("R9 low", 2'd0, 16'h0000);
        bus_4bit = 1'b0; irq_window = 1'b0;
    endtask

    task automatic t_irq_mask();
        card_present = 1'b0;
        tick();
        rd_chk("R1 again", 2'd0, 16'h0080);
        tick();
        check("R11 on", {15'd0, host_irq}, 16'd1);
        wr(2'd2, 16'h0040);
        tick();
        check("R11 masked", {15'd0, host_irq}, 16'd0);
        wr(2'd2, 16'h0080);
        check("R11 latency", {15'd0, host_irq}, 16'd0);
        tick();
        check("R11 unmasked", {15'd0, host_irq}, 16'd1);
        wr(2'd0, 16'h0080);
        tick();
        check("R11 off after clear", {15'd0, host_irq}, 16'd0);
    endtask

    task automatic t_map();
        wr(2'd1, 16'hFFFF);
        rd_chk("R12 st_en bits", 2'd1, 16'h01F0);
        wr(2'd2, 16'hFFFF);
        rd_chk("R12 sig_en bits", 2'd2, 16'h01F0);
        rd_chk("R12 addr 3", 2'd3, 16'h0000);
        wr(2'd3, 16'hFFFF);
        rd_chk("R12 addr 1 untouched", 2'd1, 16'h01F0);
    endtask

    initial begin
        rst = 1'b1;
        card_present = 1'b0; rd_buf_avail = 1'b0; wr_buf_avail = 1'b0;
        card_irq_line = 1'b0; irq_window = 1'b0; bus_4bit = 1'b0;
        reg_wr = 1'b0; reg_wr_addr = '0; reg_wr_data = '0; reg_rd_addr = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_card_edges();
        t_buffers();
        t_collision();
        t_mask();
        t_card_irq();
        t_irq_mask();
        t_map();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #40000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule